// File: doc/BRIEF.md
# Serial channel status and interrupt identification

This block gathers every condition of one asynchronous serial channel that a host needs in order to decide what to service. It brings the three modem-control inputs (clear-to-send, data-set-ready, carrier detect) into the clock domain and flags any change on them. It passes the transmit and receive levels through unchanged and latches the receive error and match events until software reads them. All of this appears in two registers on a small read port: a 16-bit status word and an 8-bit interrupt identification byte.

A single registered interrupt request is raised when any identification flag is set and the enable for that flag's class is on. The flags themselves are recorded whether or not their enable is set, so a host that polls sees the same information as one that takes interrupts. The status word's upper byte clears on a full-width read. Its lower byte always shows live state. The modem-change flags clear when the identification byte is read.

Top module: `sio_chan_status`

## Requirements
- R1: Status bits 5, 4 and 3 show the synchronized CTS, DSR and CD inputs, two clock edges after an input changes. Bits 2, 1 and 0 show tx_fifo_empty, tx_shift_empty and rx_data_avail as they are.
- R2: Status bit 15 shows stat_mode_en. Bits 13 down to 8 hold, in that order, the sticky Rx FIFO overflow, compare-2 match, compare-1 match, break, framing error and parity error flags, set by rx_evt bits 5 down to 0. Bits 14, 7 and 6 read as zero.
- R3: A status read with rd_full=1 returns the full word and then clears bits 13..8. A read with rd_full=0 returns {8'h00, low byte} and leaves bits 13..8 unchanged.
- R4: An event that arrives in the same cycle as a clearing status read is kept. The read returns the old value, and the flag stays set afterwards.
- R5: Identification bits 2, 1 and 0 are the CD, CTS and DSR change flags. Each is set three edges after its input changes, on a rising or a falling change.
- R6: A read of the identification byte (rd_sel=1) returns it and clears bits 2..0. Bit 5 (rx_trig_hit), bit 4 (tx_fifo_empty) and bit 3 (OR of status bits 13, 10, 9, 8) follow their conditions and are not cleared by that read.
- R7: Identification flags set regardless of int_en.
- R8: irq is a register. It is 1 one edge after any of these holds: (bit5 and int_en[1]), (bit4 and int_en[3]), (bit3 and int_en[2]), or (any of bits 2..0 and int_en[0]). Otherwise it is 0.
- R9: tx_drained is 1 exactly when tx_fifo_empty and tx_shift_empty are both 1.
- R10: rd_data and rd_valid are registered. They are loaded at the edge that samples rd_en=1. rd_sel=0 selects status and rd_sel=1 selects the identification byte, zero-extended.
- R11: After reset, all sticky flags, change flags, irq and rd_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_in | input | 1 | Clear-to-send input, asynchronous |
| dsr_in | input | 1 | Data-set-ready input, asynchronous |
| cd_in | input | 1 | Carrier detect input, asynchronous |
| tx_fifo_empty | input | 1 | Transmit FIFO empty level |
| tx_shift_empty | input | 1 | Transmit shifter empty level |
| rx_data_avail | input | 1 | Receive data available level |
| rx_trig_hit | input | 1 | Receive trigger level reached |
| rx_evt | input | 6 | One-cycle event pulses: 5 overflow, 4 cmp2, 3 cmp1, 2 break, 1 framing, 0 parity |
| stat_mode_en | input | 1 | Status-mode enable, shown in status bit 15 |
| int_en | input | 4 | 3 Tx-empty, 2 special receive, 1 Rx trigger, 0 modem change |
| rd_en | input | 1 | Read strobe, one cycle |
| rd_sel | input | 1 | 0 status word, 1 identification byte |
| rd_full | input | 1 | 1 full-width status read, 0 low byte only |
| rd_data | output | 16 | Read data, registered |
| rd_valid | output | 1 | rd_data loaded on the previous edge |
| tx_drained | output | 1 | Transmit path fully empty |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that each bit of rx_evt is a pulse synchronous to clk and that the three modem inputs are low while reset is asserted. With this assumption, no change is reported spuriously when reset is released. The bench changes every input only on the falling clock edge and holds the modem inputs low through reset. It gives each synchronizer at least four cycles to settle before any read that depends on it. Events and reads overlap only in the one step that is meant to test that race.

// File: rtl/sio_stat_pkg.sv
package sio_stat_pkg;
  localparam int STAT_W   = 16;
  localparam int ID_W     = 8;
  localparam int N_MODEM  = 3;   // index 0 DSR, 1 CTS, 2 CD
  localparam int N_EVT    = 6;   // index i lands on status bit 8+i
  localparam int N_EN     = 4;
  localparam int SYNC_LEN = 2;

  localparam int M_DSR = 0;
  localparam int M_CTS = 1;
  localparam int M_CD  = 2;

  localparam int E_PAR  = 0;
  localparam int E_FRM  = 1;
  localparam int E_BRK  = 2;
  localparam int E_OVF  = 5;

  localparam int EN_MODEM = 0;
  localparam int EN_RX    = 1;
  localparam int EN_SPEC  = 2;
  localparam int EN_TX    = 3;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_INTID  = 1'b1
  } rd_sel_e;
endpackage

// File: rtl/sio_modem_sync.sv
module sio_modem_sync #(
  parameter int NUM_IN = 3,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] async_in,
  input  logic              clr_i,
  output logic [NUM_IN-1:0] level_o,
  output logic [NUM_IN-1:0] delta_o
);
  for (genvar g = 0; g < NUM_IN; g++) begin : g_in
    logic [STAGES-1:0] chain_q, chain_d;
    logic              prev_q, prev_d;
    logic              dlt_q, dlt_d;
    logic              changed;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], async_in[g]};
      prev_d  = chain_q[STAGES-1];
      changed = chain_q[STAGES-1] ^ prev_q;
      dlt_d   = changed | (dlt_q & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
        dlt_q   <= 1'b0;
      end else begin
        chain_q <= chain_d;
        prev_q  <= prev_d;
        dlt_q   <= dlt_d;
      end
    end

    assign level_o[g] = chain_q[STAGES-1];
    assign delta_o[g] = dlt_q;

    // R5
    delta_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_q[STAGES-1] != prev_q) |=> dlt_q);
    // R6
    delta_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && (chain_q[STAGES-1] == prev_q)) |=> !dlt_q);
  end
endmodule

// File: rtl/sio_evt_sticky.sv
module sio_evt_sticky #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q, flags_d;

  always_comb begin
    // set has priority over a clearing read in the same cycle
    flags_d = evt_i | (flags_q & ~{N{clr_i}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R4
  evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(evt_i)) == $past(evt_i)));
  // R3
  evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && (evt_i == '0)) |=> (flags_q == '0));
  // R3
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/sio_int_id.sv
module sio_int_id
  import sio_stat_pkg::*;
#(
  parameter int NM = N_MODEM,
  parameter int NE = N_EN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic          txe_i,
  input  logic          special_i,
  input  logic [NM-1:0] delta_i,
  input  logic [NE-1:0] en_i,
  output logic [ID_W-1:0] id_o,
  output logic          irq_o
);
  logic irq_q, irq_d;
  logic modem_any;

  always_comb begin
    id_o      = '0;
    id_o[5]   = trig_i;
    id_o[4]   = txe_i;
    id_o[3]   = special_i;
    id_o[NM-1:0] = delta_i;
    modem_any = |delta_i;
    irq_d     = (trig_i    & en_i[EN_RX])   |
                (txe_i     & en_i[EN_TX])   |
                (special_i & en_i[EN_SPEC]) |
                (modem_any & en_i[EN_MODEM]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R8
  irq_modem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|delta_i) && en_i[EN_MODEM]) |=> irq_q);
  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && !txe_i && !special_i && (delta_i == '0)) |=> !irq_q);
endmodule

// File: rtl/sio_chan_status.sv
module sio_chan_status
  import sio_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cts_in,
  input  logic              dsr_in,
  input  logic              cd_in,
  input  logic              tx_fifo_empty,
  input  logic              tx_shift_empty,
  input  logic              rx_data_avail,
  input  logic              rx_trig_hit,
  input  logic [N_EVT-1:0]  rx_evt,
  input  logic              stat_mode_en,
  input  logic [N_EN-1:0]   int_en,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic              rd_full,
  output logic [STAT_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              tx_drained,
  output logic              irq
);
  logic [N_MODEM-1:0] modem_raw, modem_lvl, modem_dlt;
  logic [N_EVT-1:0]   evt_flags;
  logic [ID_W-1:0]    id_byte;
  logic [STAT_W-1:0]  status_word;
  logic               clr_sticky, clr_delta, special;
  logic [STAT_W-1:0]  rd_data_q, rd_data_d;
  logic               rd_valid_q;
  rd_sel_e            sel;

  always_comb begin
    modem_raw        = '0;
    modem_raw[M_DSR] = dsr_in;
    modem_raw[M_CTS] = cts_in;
    modem_raw[M_CD]  = cd_in;
  end

  assign sel        = rd_sel_e'(rd_sel);
  assign clr_sticky = rd_en & (sel == SEL_STATUS) & rd_full;
  assign clr_delta  = rd_en & (sel == SEL_INTID);

  sio_modem_sync #(.NUM_IN(N_MODEM), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(modem_raw), .clr_i(clr_delta),
    .level_o(modem_lvl), .delta_o(modem_dlt));

  sio_evt_sticky #(.N(N_EVT)) u_sticky (
    .clk(clk), .rst_n(rst_n), .evt_i(rx_evt), .clr_i(clr_sticky),
    .flags_o(evt_flags));

  assign special = evt_flags[E_OVF] | evt_flags[E_BRK] |
                   evt_flags[E_FRM] | evt_flags[E_PAR];

  sio_int_id #(.NM(N_MODEM), .NE(N_EN)) u_id (
    .clk(clk), .rst_n(rst_n), .trig_i(rx_trig_hit), .txe_i(tx_fifo_empty),
    .special_i(special), .delta_i(modem_dlt), .en_i(int_en),
    .id_o(id_byte), .irq_o(irq));

  always_comb begin
    status_word                  = '0;
    status_word[15]              = stat_mode_en;
    status_word[8 +: N_EVT]      = evt_flags;
    status_word[5]               = modem_lvl[M_CTS];
    status_word[4]               = modem_lvl[M_DSR];
    status_word[3]               = modem_lvl[M_CD];
    status_word[2]               = tx_fifo_empty;
    status_word[1]               = tx_shift_empty;
    status_word[0]               = rx_data_avail;
  end

  always_comb begin
    rd_data_d = rd_data_q;
    if (rd_en) begin
      if (sel == SEL_INTID)  rd_data_d = {{(STAT_W-ID_W){1'b0}}, id_byte};
      else if (rd_full)      rd_data_d = status_word;
      else                   rd_data_d = {8'h00, status_word[7:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_data_q  <= rd_data_d;
      rd_valid_q <= rd_en;
    end
  end

  assign rd_data    = rd_data_q;
  assign rd_valid   = rd_valid_q;
  assign tx_drained = tx_fifo_empty & tx_shift_empty;

  // R10
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R2
  mode_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel && rd_full) |=> (rd_data[15] == $past(stat_mode_en)));
  // R6
  id_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel) |=> (rd_data[15:6] == '0));
endmodule

// File: tb/sio_chan_status_test.sv
module sio_chan_status_test;
  logic clk = 1'b0;
  logic rst_n;
  logic cts_in, dsr_in, cd_in;
  logic tx_fifo_empty, tx_shift_empty, rx_data_avail, rx_trig_hit;
  logic [5:0] rx_evt;
  logic stat_mode_en;
  logic [3:0] int_en;
  logic rd_en, rd_sel, rd_full;
  logic [15:0] rd_data;
  logic rd_valid, tx_drained, irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  string req_q[$];

  always #10 clk = ~clk;

  sio_chan_status uut (
    .clk(clk), .rst_n(rst_n), .cts_in(cts_in), .dsr_in(dsr_in), .cd_in(cd_in),
    .tx_fifo_empty(tx_fifo_empty), .tx_shift_empty(tx_shift_empty),
    .rx_data_avail(rx_data_avail), .rx_trig_hit(rx_trig_hit), .rx_evt(rx_evt),
    .stat_mode_en(stat_mode_en), .int_en(int_en), .rd_en(rd_en),
    .rd_sel(rd_sel), .rd_full(rd_full), .rd_data(rd_data),
    .rd_valid(rd_valid), .tx_drained(tx_drained), .irq(irq));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: issue a read and push its expected result
  task automatic do_read(input logic sel, input logic full,
                         input logic [15:0] exp, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel; rd_full = full;
    exp_q.push_back(exp); req_q.push_back(req);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_evt(input logic [5:0] v);
    @(negedge clk);
    rx_evt = v;
    @(negedge clk);
    rx_evt = '0;
  endtask

  // monitor: pop and compare each returned read
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R10: unexpected read data %h expected none", rd_data);
      end else begin
        chk(rd_data, exp_q.pop_front(), req_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cts_in = 0; dsr_in = 0; cd_in = 0;
    tx_fifo_empty = 0; tx_shift_empty = 0; rx_data_avail = 0; rx_trig_hit = 0;
    rx_evt = '0; stat_mode_en = 0; int_en = '0;
    rd_en = 0; rd_sel = 0; rd_full = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R11 reset state
    chk({15'd0, irq}, 16'h0, "R11 irq");
    chk({15'd0, rd_valid}, 16'h0, "R11 rd_valid");
    do_read(1'b0, 1'b1, 16'h0000, "R11 status");
    do_read(1'b1, 1'b0, 16'h0000, "R11 intid");

    // R1 live low byte, R9 drained
    tx_fifo_empty = 1; tx_shift_empty = 1; rx_data_avail = 1;
    cyc(1);
    chk({15'd0, tx_drained}, 16'h1, "R9 both empty");
    do_read(1'b0, 1'b0, 16'h0007, "R1 live bits");
    tx_shift_empty = 0;
    cyc(1);
    chk({15'd0, tx_drained}, 16'h0, "R9 shifter busy");
    tx_shift_empty = 1; rx_data_avail = 0;

    // R5 rising CTS, R6 clear of change flag
    cts_in = 1;
    cyc(4);
    do_read(1'b0, 1'b1, 16'h0026, "R1 cts level");
    do_read(1'b1, 1'b0, 16'h0012, "R5 cts rise");
    do_read(1'b1, 1'b0, 16'h0010, "R6 delta cleared, txe level kept");

    // R5 falling and rising on several inputs
    cts_in = 0; dsr_in = 1; cd_in = 1;
    cyc(4);
    do_read(1'b0, 1'b1, 16'h001E, "R1 dsr cd level");
    do_read(1'b1, 1'b0, 16'h0017, "R5 both directions");
    do_read(1'b1, 1'b0, 16'h0010, "R6 deltas cleared");
    tx_fifo_empty = 0; tx_shift_empty = 0;

    // R3 sticky, low-only read keeps, full read clears
    pulse_evt(6'h01);
    do_read(1'b0, 1'b0, 16'h0018, "R3 low-only read");
    do_read(1'b1, 1'b0, 16'h0008, "R6 special level");
    do_read(1'b0, 1'b1, 16'h0118, "R3 parity kept");
    do_read(1'b0, 1'b1, 16'h0018, "R3 cleared");
    do_read(1'b1, 1'b0, 16'h0000, "R6 special follows");

    // R4 event in the same cycle as a clearing read
    @(negedge clk);
    rx_evt = 6'h02; rd_en = 1; rd_sel = 0; rd_full = 1;
    exp_q.push_back(16'h0018); req_q.push_back("R4 old value returned");
    @(negedge clk);
    rx_evt = '0; rd_en = 0;
    do_read(1'b0, 1'b1, 16'h0218, "R4 event survives");
    do_read(1'b0, 1'b1, 16'h0018, "R3 cleared after race");

    // R2 all event bits and mode bit
    stat_mode_en = 1;
    pulse_evt(6'h3F);
    do_read(1'b0, 1'b1, 16'hBF18, "R2 high byte");
    do_read(1'b0, 1'b1, 16'h8018, "R2 mode bit survives clear");
    stat_mode_en = 0;

    // R7 flags set with enables off, R8 irq
    cts_in = 1;
    cyc(4);
    chk({15'd0, irq}, 16'h0, "R7 irq masked");
    int_en = 4'b0001;
    cyc(2);
    chk({15'd0, irq}, 16'h1, "R8 modem irq");
    do_read(1'b1, 1'b0, 16'h0002, "R7 flag set while disabled");
    cyc(2);
    chk({15'd0, irq}, 16'h0, "R8 irq drops after clear");

    int_en = 4'b0000; rx_trig_hit = 1;
    cyc(2);
    chk({15'd0, irq}, 16'h0, "R7 trig masked");
    do_read(1'b1, 1'b0, 16'h0020, "R7 trig flag");
    do_read(1'b1, 1'b0, 16'h0020, "R6 trig level kept");
    int_en = 4'b0010;
    cyc(2);
    chk({15'd0, irq}, 16'h1, "R8 rx irq");
    rx_trig_hit = 0;
    cyc(2);
    chk({15'd0, irq}, 16'h0, "R8 rx irq drops");

    int_en = 4'b1000; tx_fifo_empty = 1;
    cyc(2);
    chk({15'd0, irq}, 16'h1, "R8 tx irq");
    int_en = 4'b0000;
    cyc(2);
    chk({15'd0, irq}, 16'h0, "R8 tx irq masked");

    int_en = 4'b0100;
    pulse_evt(6'h04);
    cyc(2);
    chk({15'd0, irq}, 16'h1, "R8 special irq");
    do_read(1'b0, 1'b1, 16'h043C, "R3 break read");
    cyc(2);
    chk({15'd0, irq}, 16'h0, "R8 special irq drops");

    cyc(3);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R10: actual %0d reads outstanding expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule